// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This block is the control logic between a host microcontroller and the contacts of a contact smart card. It decides when the card supply converter runs and which card signals may move. It also sets the direction of the data line on both sides. On a power-up request from the host, with a card inserted, it enables the converter and latches the requested card voltage. It then keeps every card contact low until the converter reports that the supply is good. After that it opens the data path and finally gates the card clock on. Card reset never rises by itself: it follows the host's reset request once the card is live, so the answer-to-reset is always started by the host.

A deactivation runs in a fixed order, with a programmable number of cycles between steps: reset low, then clock stopped, then data line driven low, then supply off. It starts on a host power-down request or on a debounced card removal. It also starts when the supply fails to come good within a timeout, and in that case a fault flag is raised. While the card is powered, chip-select has no say over the supply. When chip-select is high, the host-side data line is released so that it cannot collide with other host traffic.

All data lines are open-drain. An output named `*_low` at 1 pulls the line low, and at 0 releases it (high impedance).

Top module: `sc_pwr_seq`

## Requirements
- R1: After reset and in standby (`conv_en` = 0): `card_rst` = 0, `card_clk_en` = 0, `card_io_low` = 1, `host_io_low` = 0 and `fault` = 0.
- R2: A power-up request is `pwr_req` = 1 with `chip_sel` = 0. In standby, with the debounced card present and `fault` = 0, it sets `conv_en` on the next clock. The same edge latches `vsel` into `conv_vsel` (1 = 5.0 V, 0 = 3.0 V), which holds until the next power-up.
- R3: While the supply ramps (`conv_en` = 1, `supply_good` not yet seen), `card_rst` = 0, `card_clk_en` = 0 and `card_io_low` = 1, whatever the host drives.
- R4: The clock edge that samples `supply_good` = 1 during the ramp opens the data path. From then on `card_io_low` = NOT `host_io_in`. Exactly STEP_CYC cycles later `card_clk_en` goes to 1.
- R5: `card_rst` equals `host_rst` only while the card is live (data path open and clock on, no deactivation running). It is 0 at all other times.
- R6: `host_io_low` is 0 whenever `chip_sel` = 1. With the data path open and `chip_sel` = 0, it equals NOT `card_io_in`.
- R7: Once the supply is on, `pwr_req` changes made while `chip_sel` = 1 do not start a deactivation. Only `pwr_req` = 0 together with `chip_sel` = 0 is a power-down request.
- R8: Deactivation order: `card_rst` goes low in the first cycle. `card_clk_en` goes low STEP_CYC cycles later, `card_io_low` goes to 1 another STEP_CYC cycles later, and `conv_en` goes low another STEP_CYC cycles later.
- R9: The debounced card state changes only after `card_present` has held the new level for DEB_CYC consecutive samples, so shorter pulses have no effect. Removal aborts activation at any point, including the ramp, and starts the deactivation.
- R10: If `supply_good` has not been sampled high by the ramp's TMO_CYC-th clock edge, deactivation starts and `fault` goes to 1. While `fault` = 1, power-up requests are ignored. A power-down request clears `fault` on the next clock.
- R11: When several events fall on the same edge during the ramp, abort (power-down request or removal) beats `supply_good`, and `supply_good` beats the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_req | input | 1 | Host power request level |
| chip_sel | input | 1 | Host chip-select, 0 = selected |
| vsel | input | 1 | Requested card voltage, 1 = 5.0 V, 0 = 3.0 V |
| card_present | input | 1 | Raw card-presence sense, 1 = inserted |
| supply_good | input | 1 | Card supply has reached its programmed level |
| host_rst | input | 1 | Host's card reset request |
| host_io_in | input | 1 | Level of the host-side data line |
| card_io_in | input | 1 | Level driven by the card on its data line |
| conv_en | output | 1 | Supply converter enable |
| conv_vsel | output | 1 | Latched voltage select for the converter |
| card_rst | output | 1 | Card reset contact |
| card_clk_en | output | 1 | Card clock gate |
| card_io_low | output | 1 | Pull card data line low (0 = release) |
| host_io_low | output | 1 | Pull host data line low (0 = high impedance) |
| fault | output | 1 | Supply timeout fault, sticky |

## Verification
Two pairs of events can meet on one ramp edge. In the first, `supply_good` arrives on the very edge where the timeout would expire. In the second, the debounced removal takes effect on the same edge as `supply_good`. The bench places `supply_good` one half-cycle before the critical edge, using its own model's ramp count and debounced card state to find that edge. It then judges the outcome at the ports. A timeout loss shows as an open data path with no fault. An abort win shows as a data line still held low, the clock never gated, and the supply going through the normal off sequence.

// File: rtl/sc_pwr_pkg.sv
package sc_pwr_pkg;

  typedef enum logic [2:0] {
    ST_STBY = 3'd0,  // converter off, contacts low
    ST_RAMP = 3'd1,  // converter on, waiting for supply good
    ST_IOEN = 3'd2,  // data path open, clock still held
    ST_LIVE = 3'd3,  // card live
    ST_DRST = 3'd4,  // teardown: reset low
    ST_DCLK = 3'd5,  // teardown: clock stopped
    ST_DIO  = 3'd6   // teardown: data low, supply about to drop
  } seq_st_t;

  // larger of two lengths, used to size the shared counter
  function automatic int unsigned span_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // true on the last cycle of a window of len cycles counted from zero
  function automatic logic hit_last(input logic [31:0] cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  // states whose residence is measured by the shared counter
  function automatic logic seq_timed(input seq_st_t s);
    return s inside {ST_RAMP, ST_IOEN, ST_DRST, ST_DCLK, ST_DIO};
  endfunction

  // a state from which an abort is honoured
  function automatic logic seq_abortable(input seq_st_t s);
    return s inside {ST_RAMP, ST_IOEN, ST_LIVE};
  endfunction

endpackage

// File: rtl/sc_deb.sv
module sc_deb
  import sc_pwr_pkg::*;
#(
  parameter int unsigned DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic stable
);
  localparam int unsigned DW = $clog2(DEB_CYC + 1);

  logic [DW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable <= 1'b0;
      run    <= '0;
    end else if (raw == stable) begin
      run <= '0;
    end else if (hit_last(32'(run), DEB_CYC)) begin
      stable <= raw;
      run    <= '0;
    end else begin
      run <= run + DW'(1);
    end
  end
endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_pwr_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4,
  parameter int unsigned TMO_CYC  = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pu_req,
  input  logic    pd_req,
  input  logic    card_in,
  input  logic    supply_good,
  input  logic    vsel,
  output seq_st_t st,
  output logic    io_on,
  output logic    clk_on,
  output logic    fault,
  output logic    vsel_q,
  output logic    ev_abort,
  output logic    ev_tmo
);
  localparam int unsigned CMAX = span_max(STEP_CYC, TMO_CYC);
  localparam int unsigned CW   = $clog2(CMAX + 1);

  seq_st_t       st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          abort_src, ev_start, ev_good, step_end, ramp_end;
  logic          io_on_nx, clk_on_nx;

  assign abort_src = pd_req || !card_in;
  assign step_end  = hit_last(32'(cnt), STEP_CYC);
  assign ramp_end  = hit_last(32'(cnt), TMO_CYC);
  assign ev_start  = (st == ST_STBY) && pu_req && card_in && !fault;
  assign ev_abort  = seq_abortable(st) && abort_src;
  assign ev_good   = (st == ST_RAMP) && !abort_src && supply_good;
  assign ev_tmo    = (st == ST_RAMP) && !abort_src && !supply_good && ramp_end;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_STBY: if (ev_start) st_nx = ST_RAMP;
      ST_RAMP: begin
        if (ev_abort || ev_tmo) st_nx = ST_DRST;
        else if (ev_good)       st_nx = ST_IOEN;
      end
      ST_IOEN: begin
        if (ev_abort)      st_nx = ST_DRST;
        else if (step_end) st_nx = ST_LIVE;
      end
      ST_LIVE: if (ev_abort) st_nx = ST_DRST;
      ST_DRST: if (step_end) st_nx = ST_DCLK;
      ST_DCLK: if (step_end) st_nx = ST_DIO;
      ST_DIO:  if (step_end) st_nx = ST_STBY;
      default: st_nx = ST_STBY;
    endcase
  end

  always_comb begin
    if ((st_nx != st) || !seq_timed(st)) cnt_nx = '0;
    else                                 cnt_nx = cnt + CW'(1);
  end

  // the data path and clock flags open on the way up and are each
  // held through the teardown steps that precede their own turn
  always_comb begin
    unique case (st_nx)
      ST_IOEN:          io_on_nx = 1'b1;
      ST_LIVE:          io_on_nx = 1'b1;
      ST_DRST, ST_DCLK: io_on_nx = io_on;
      default:          io_on_nx = 1'b0;
    endcase
    unique case (st_nx)
      ST_LIVE: clk_on_nx = 1'b1;
      ST_DRST: clk_on_nx = clk_on;
      default: clk_on_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_STBY;
      cnt    <= '0;
      io_on  <= 1'b0;
      clk_on <= 1'b0;
      fault  <= 1'b0;
      vsel_q <= 1'b0;
    end else begin
      st     <= st_nx;
      cnt    <= cnt_nx;
      io_on  <= io_on_nx;
      clk_on <= clk_on_nx;
      if (ev_tmo)      fault <= 1'b1;
      else if (pd_req) fault <= 1'b0;
      if (ev_start) vsel_q <= vsel;
    end
  end
endmodule

// File: rtl/sc_io_ctl.sv
module sc_io_ctl
  import sc_pwr_pkg::*;
(
  input  seq_st_t st,
  input  logic    io_on,
  input  logic    clk_on,
  input  logic    host_rst,
  input  logic    host_io_in,
  input  logic    card_io_in,
  input  logic    chip_sel,
  output logic    conv_en,
  output logic    card_rst,
  output logic    card_clk_en,
  output logic    card_io_low,
  output logic    host_io_low
);
  assign conv_en     = (st != ST_STBY);
  assign card_rst    = (st == ST_LIVE) && host_rst;
  assign card_clk_en = clk_on;
  // closed path: card line clamped low; open path: mirror host level
  assign card_io_low = !io_on || !host_io_in;
  // host side released whenever chip-select is high
  assign host_io_low = io_on && !chip_sel && !card_io_in;
endmodule

// File: rtl/sc_pwr_seq.sv
module sc_pwr_seq
  import sc_pwr_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4,
  parameter int unsigned TMO_CYC  = 64,
  parameter int unsigned DEB_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic chip_sel,
  input  logic vsel,
  input  logic card_present,
  input  logic supply_good,
  input  logic host_rst,
  input  logic host_io_in,
  input  logic card_io_in,
  output logic conv_en,
  output logic conv_vsel,
  output logic card_rst,
  output logic card_clk_en,
  output logic card_io_low,
  output logic host_io_low,
  output logic fault
);
  seq_st_t st;
  logic    card_in, pu_req, pd_req, io_on, clk_on;
  logic    ev_abort, ev_tmo;

  assign pu_req = pwr_req && !chip_sel;
  assign pd_req = !pwr_req && !chip_sel;

  sc_deb #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (card_present),
    .stable (card_in)
  );

  sc_seq_fsm #(.STEP_CYC(STEP_CYC), .TMO_CYC(TMO_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pu_req      (pu_req),
    .pd_req      (pd_req),
    .card_in     (card_in),
    .supply_good (supply_good),
    .vsel        (vsel),
    .st          (st),
    .io_on       (io_on),
    .clk_on      (clk_on),
    .fault       (fault),
    .vsel_q      (conv_vsel),
    .ev_abort    (ev_abort),
    .ev_tmo      (ev_tmo)
  );

  sc_io_ctl u_io (
    .st          (st),
    .io_on       (io_on),
    .clk_on      (clk_on),
    .host_rst    (host_rst),
    .host_io_in  (host_io_in),
    .card_io_in  (card_io_in),
    .chip_sel    (chip_sel),
    .conv_en     (conv_en),
    .card_rst    (card_rst),
    .card_clk_en (card_clk_en),
    .card_io_low (card_io_low),
    .host_io_low (host_io_low)
  );
endmodule

// File: rtl/sc_pwr_seq_chk.sv
module sc_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_req,
  input logic chip_sel,
  input logic card_present,
  input logic host_rst,
  input logic conv_en,
  input logic card_rst,
  input logic card_clk_en,
  input logic card_io_low,
  input logic host_io_low,
  input logic fault,
  input logic conv_vsel,
  input logic card_in,
  input logic ev_abort,
  input logic ev_tmo
);
  AST_STANDBY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |-> (!card_rst && !card_clk_en && card_io_low && !host_io_low)); // R1
  AST_PWRUP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en) |-> $past(pwr_req && !chip_sel)); // R2
  AST_VSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && $past(conv_en)) |-> $stable(conv_vsel)); // R2
  AST_RAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en) |-> (!card_rst && !card_clk_en && card_io_low)); // R3
  AST_CLK_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_en |-> conv_en); // R4
  AST_RST_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (host_rst && card_clk_en)); // R5
  AST_HOST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel |-> !host_io_low); // R6
  AST_CS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && chip_sel) |-> !card_in); // R7
  AST_CLK_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en) |-> !card_rst); // R8
  AST_SUPPLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_en) |-> (!card_clk_en && card_io_low)); // R8
  AST_DEB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_in) |-> $past(!card_present)); // R9
  AST_TMO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> fault); // R10
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(!pwr_req && !chip_sel)); // R10
endmodule

bind sc_pwr_seq sc_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_req      (pwr_req),
  .chip_sel     (chip_sel),
  .card_present (card_present),
  .host_rst     (host_rst),
  .conv_en      (conv_en),
  .card_rst     (card_rst),
  .card_clk_en  (card_clk_en),
  .card_io_low  (card_io_low),
  .host_io_low  (host_io_low),
  .fault        (fault),
  .conv_vsel    (conv_vsel),
  .card_in      (card_in),
  .ev_abort     (ev_abort),
  .ev_tmo       (ev_tmo)
);

// File: tb/sc_pwr_seq_bench.sv
module sc_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEP  = 3;
  localparam int TMO   = 12;
  localparam int DEB   = 4;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_req = 1'b0, chip_sel = 1'b1, vsel = 1'b0, card_present = 1'b0;
  logic supply_good = 1'b0, host_rst = 1'b0, host_io_in = 1'b1, card_io_in = 1'b1;
  logic conv_en, conv_vsel, card_rst, card_clk_en, card_io_low, host_io_low, fault;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sc_pwr_seq #(.STEP_CYC(STEP), .TMO_CYC(TMO), .DEB_CYC(DEB)) u_sc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .chip_sel(chip_sel), .vsel(vsel),
    .card_present(card_present), .supply_good(supply_good), .host_rst(host_rst),
    .host_io_in(host_io_in), .card_io_in(card_io_in), .conv_en(conv_en),
    .conv_vsel(conv_vsel), .card_rst(card_rst), .card_clk_en(card_clk_en),
    .card_io_low(card_io_low), .host_io_low(host_io_low), .fault(fault)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 standby, 1 ramp, 2 path open, 3 live, 4/5/6 teardown steps
  int m_ph = 0, m_cnt = 0, nph = 0;
  bit m_db = 0, m_fault = 0, m_vsel = 0, m_io = 0, m_clk = 0;
  bit pu_s, pd_s, ab_s, to_s, flip;
  bit hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_db = 0; m_fault = 0; m_vsel = 0; m_io = 0; m_clk = 0;
      hist.delete();
    end else begin
      pu_s = pwr_req && !chip_sel;
      pd_s = !pwr_req && !chip_sel;
      ab_s = pd_s || !m_db;
      to_s = 0;
      nph  = m_ph;
      if (m_ph == 0) begin
        if (pu_s && m_db && !m_fault) begin nph = 1; m_vsel = vsel; end
      end else if (m_ph == 1) begin
        if (ab_s) nph = 4;
        else if (supply_good) nph = 2;
        else if (m_cnt == TMO - 1) begin nph = 4; to_s = 1; end
      end else if (m_ph == 2) begin
        if (ab_s) nph = 4; else if (m_cnt == STEP - 1) nph = 3;
      end else if (m_ph == 3) begin
        if (ab_s) nph = 4;
      end else begin
        if (m_cnt == STEP - 1) nph = (m_ph == 6) ? 0 : m_ph + 1;
      end
      if (to_s) m_fault = 1; else if (pd_s) m_fault = 0;
      if (nph == 2 || nph == 3) m_io = 1; else if (nph != 4 && nph != 5) m_io = 0;
      if (nph == 3) m_clk = 1; else if (nph != 4) m_clk = 0;
      if (nph != m_ph || m_ph == 0 || m_ph == 3) m_cnt = 0; else m_cnt = m_cnt + 1;
      m_ph = nph;
      hist.push_back(card_present);
      if (hist.size() > DEB) void'(hist.pop_front());
      flip = (hist.size() == DEB);
      foreach (hist[i]) if (hist[i] == m_db) flip = 0;
      if (flip) m_db = !m_db;
    end
  end

  // ---------------- every-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "conv_en", conv_en, m_ph != 0);
      chk("R2", "conv_vsel", conv_vsel, m_vsel);
      chk("R5", "card_rst", card_rst, (m_ph == 3) && host_rst);
      chk("R4", "card_clk_en", card_clk_en, m_clk);
      chk("R3", "card_io_low", card_io_low, !m_io || !host_io_in);
      chk("R6", "host_io_low", host_io_low, m_io && !chip_sel && !card_io_in);
      chk("R10", "fault", fault, m_fault);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_conv(input logic lvl);
    for (int k = 0; k < 60 && conv_en !== lvl; k++) tick(1);
  endtask

  int t0, t1, t2, t3;

  initial begin
    tick(3);
    // R1: outputs held during reset
    chk("R1", "reset conv_en", conv_en, 0);
    chk("R1", "reset card_io_low", card_io_low, 1);
    chk("R1", "reset card_clk_en", card_clk_en, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "standby host_io_low", host_io_low, 0);
    chk("R1", "standby fault", fault, 0);

    // R9: short presence pulse ignored while a request is pending
    pwr_req = 1; chip_sel = 0; vsel = 1;
    card_present = 1; tick(DEB - 2); card_present = 0;
    tick(8);
    chk("R9", "glitch no power-up", conv_en, 0);

    // R2: power-up with voltage latch
    card_present = 1;
    wait_conv(1);
    chk("R2", "conv_en up", conv_en, 1);
    chk("R2", "vsel latched 5V", conv_vsel, 1);
    vsel = 0; tick(1);
    chk("R2", "vsel held", conv_vsel, 1);

    // R3: ramp keeps contacts low despite host activity
    host_rst = 1; host_io_in = 0; tick(3);
    chk("R3", "ramp card_rst", card_rst, 0);
    chk("R3", "ramp card_io_low", card_io_low, 1);
    chk("R3", "ramp card_clk_en", card_clk_en, 0);
    host_rst = 0; host_io_in = 1;

    // R4: activation order and spacing
    supply_good = 1;
    t0 = -1; t1 = -1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (t0 < 0 && card_io_low == 0) t0 = i;
      if (t1 < 0 && card_clk_en == 1) t1 = i;
    end
    chk("R4", "path opens first", t0, 0);
    chk("R4", "clock after STEP", t1 - t0, STEP);

    // R5: reset follows host only when live
    host_rst = 1; tick(1);
    chk("R5", "card_rst follows host", card_rst, 1);
    host_rst = 0; tick(1);
    chk("R5", "card_rst released", card_rst, 0);

    // R6: host side direction
    card_io_in = 0; tick(1);
    chk("R6", "host pulled low", host_io_low, 1);
    chip_sel = 1; tick(1);
    chk("R6", "host hi-z on cs high", host_io_low, 0);
    card_io_in = 1;

    // R7: supply locked while deselected
    pwr_req = 0; tick(5);
    chk("R7", "supply kept", conv_en, 1);
    chk("R7", "clock kept", card_clk_en, 1);
    pwr_req = 1; chip_sel = 0;

    // R8: deactivation order
    host_rst = 1; tick(1);
    chk("R8", "reset high before teardown", card_rst, 1);
    pwr_req = 0;
    t0 = -1; t1 = -1; t2 = -1; t3 = -1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (t0 < 0 && card_rst == 0) t0 = i;
      if (t1 < 0 && card_clk_en == 0) t1 = i;
      if (t2 < 0 && card_io_low == 1) t2 = i;
      if (t3 < 0 && conv_en == 0) t3 = i;
    end
    chk("R8", "reset first", t0, 0);
    chk("R8", "clock after STEP", t1 - t0, STEP);
    chk("R8", "data after STEP", t2 - t1, STEP);
    chk("R8", "supply after STEP", t3 - t2, STEP);
    host_rst = 0;

    // R10: supply timeout
    supply_good = 0; pwr_req = 1;
    wait_conv(1);
    tick(TMO + 3 * STEP + 4);
    chk("R10", "fault set", fault, 1);
    chk("R10", "supply removed", conv_en, 0);
    tick(6);
    chk("R10", "fault blocks restart", conv_en, 0);
    pwr_req = 0; tick(2);
    chk("R10", "fault cleared", fault, 0);

    // R9: removal during ramp
    pwr_req = 1;
    wait_conv(1);
    card_present = 0;
    tick(DEB + 3 * STEP + 6);
    chk("R9", "removal tears down", conv_en, 0);
    chk("R9", "removal no fault", fault, 0);

    // R11: supply good on the timeout edge
    card_present = 1;
    wait_conv(1);
    for (int k = 0; k < 40 && !(m_ph == 1 && m_cnt == TMO - 1); k++) tick(1);
    supply_good = 1; tick(2);
    chk("R11", "good beats timeout: path", card_io_low, 0);
    chk("R11", "good beats timeout: fault", fault, 0);
    pwr_req = 0; tick(3 * STEP + 4);
    supply_good = 0; pwr_req = 1;
    wait_conv(1);

    // R11: removal on the supply-good edge
    card_present = 0;
    for (int k = 0; k < 20 && m_db != 0; k++) tick(1);
    supply_good = 1; tick(2);
    chk("R11", "abort beats good: data low", card_io_low, 1);
    chk("R11", "abort beats good: no clock", card_clk_en, 0);
    tick(3 * STEP + 4);
    chk("R11", "abort beats good: supply off", conv_en, 0);
    supply_good = 0;

    tick(3);
    finish_run();
  end
endmodule